// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block merges level-sensitive interrupt sources into a single processor interrupt request with an 8-bit trap vector. The sources are a 16-bit external pending-level vector and a 17-bit software interrupt register. Two timer-match bits in the software register do not map to their own levels. When either one is set, level 14 counts as pending.

Each clock the block compares the merged pending set against a 4-bit processor interrupt level threshold and a global enable. It takes the trap level and the trap type now in service into account, then registers a request flag and a vector. The highest pending level above the threshold wins. Its vector is 0x40 ORed with the level. A new vector is not raised when a trap of higher type is already being serviced at a nonzero trap level.

Top module: `irq_level_arb`

## Requirements
- R1: The pending set is the bitwise OR of `ext_lvl_i[15:0]` with `soft_int_i[15:0]`. Software bit 0 (tick match) and bit 16 (system-tick match) do not enter this OR directly.
- R2: If `soft_int_i[0]` or `soft_int_i[16]` is set, level 14 is treated as pending.
- R3: If the pending set, read as an unsigned number, is below `2 << pil_i`, then on the next clock `irq_o` is 0 and `vec_o` is 0x00. In particular, with `pil_i` = 15 nothing is ever raised. Whenever `irq_o` is 0, `vec_o` is 0x00.
- R4: With interrupts enabled, the winning level is the highest pending level strictly above `pil_i`.
- R5: The vector for winning level L is 0x40 | L, so it lies in the range 0x41 to 0x4F.
- R6: If `trap_lvl_i` is nonzero and `trap_type_i` is greater than the candidate vector, the request and the vector keep their previous values. If `trap_type_i` equals the candidate vector or is below it, the candidate is not blocked.
- R7: With `int_en_i` low and a pending set not below the threshold, an active request is cleared and `vec_o` returns to 0x00. An inactive request stays inactive.
- R8: Outputs are registered with one clock of latency. If a candidate is not blocked and differs from the latched vector, the new vector is latched and `irq_o` is set. If it is equal to the latched vector, both outputs keep their values.
- R9: An asynchronous active-low reset clears `irq_o` and `vec_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_lvl_i | input | 16 | External pending levels, bit n = level n |
| soft_int_i | input | 17 | Software interrupt register; bit 0 tick match, bit 16 system-tick match |
| pil_i | input | 4 | Processor interrupt level threshold |
| int_en_i | input | 1 | Global interrupt enable |
| trap_lvl_i | input | TL_W (3) | Current trap level |
| trap_type_i | input | TT_W (9) | Trap type in service |
| irq_o | output | 1 | Hard interrupt request |
| vec_o | output | 8 | Interrupt vector index |

## Verification
The only state is the latched request and vector. A wrong value in either one appears at the ports one clock after the inputs that caused it. A vector that is stuck or out of date shows up in two ways. A blocked preemption may fail to hold the old vector. An unchanged candidate may fail to keep the request asserted. Each scenario therefore sets up a known latched vector first and then checks the very next cycle. If the threshold comparison or the level scan is off by one, the wrong level appears in `vec_o[3:0]` in that same cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NUM_LVL   = 16;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned SOFT_W    = 17;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned TICK_BIT  = 0;
  localparam int unsigned STICK_BIT = 16;
  localparam int unsigned TIMER_LVL = 14;
  localparam logic [VEC_W-1:0] EXT_TT_BASE = 8'h40;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge
  import irq_arb_pkg::*;
(
  input  logic [NUM_LVL-1:0] ext_lvl_i,
  input  logic [SOFT_W-1:0]  soft_int_i,
  output logic [NUM_LVL-1:0] pend_o
);
  logic timer_hit;
  logic [NUM_LVL-1:0] soft_lvl;

  assign timer_hit = soft_int_i[TICK_BIT] | soft_int_i[STICK_BIT];

  always_comb begin
    soft_lvl = soft_int_i[NUM_LVL-1:0];
    soft_lvl[TICK_BIT] = 1'b0;  // timer bits never map to their own level
    pend_o = ext_lvl_i | soft_lvl;
    if (timer_hit) pend_o[TIMER_LVL] = 1'b1;
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
(
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [LVL_W-1:0]   pil_i,
  output logic               hit_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_LVL-1:0] above;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_above
    assign above[g] = pend_i[g] && (LVL_W'(g) > pil_i);
  end

  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (above[i]) begin
        hit_o = 1'b1;
        lvl_o = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned TL_W = 3,
  parameter int unsigned TT_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LVL-1:0]   ext_lvl_i,
  input  logic [SOFT_W-1:0]    soft_int_i,
  input  logic [LVL_W-1:0]     pil_i,
  input  logic                 int_en_i,
  input  logic [TL_W-1:0]      trap_lvl_i,
  input  logic [TT_W-1:0]      trap_type_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam int unsigned CMP_W = NUM_LVL + 1;

  logic [NUM_LVL-1:0] pend;
  logic               hit;
  logic [LVL_W-1:0]   win_lvl;
  logic               below;
  logic [VEC_W-1:0]   cand_vec;
  logic               blocked;
  logic               irq_d, irq_q;
  logic [VEC_W-1:0]   vec_d, vec_q;

  irq_pend_merge i_merge (
    .ext_lvl_i  (ext_lvl_i),
    .soft_int_i (soft_int_i),
    .pend_o     (pend)
  );

  irq_level_pick i_pick (
    .pend_i (pend),
    .pil_i  (pil_i),
    .hit_o  (hit),
    .lvl_o  (win_lvl)
  );

  assign below    = {1'b0, pend} < (CMP_W'(2) << pil_i);
  assign cand_vec = EXT_TT_BASE | VEC_W'(win_lvl);
  assign blocked  = (trap_lvl_i != '0) && (trap_type_i > TT_W'(cand_vec));

  always_comb begin
    irq_d = irq_q;
    vec_d = vec_q;
    if (below) begin
      irq_d = 1'b0;
      vec_d = '0;
    end else if (int_en_i) begin
      if (hit && !blocked && (cand_vec != vec_q)) begin
        irq_d = 1'b1;
        vec_d = cand_vec;
      end
    end else if (irq_q) begin
      irq_d = 1'b0;
      vec_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned TL_W = 3,
  parameter int unsigned TT_W = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_LVL-1:0] ext_lvl_i,
  input logic [SOFT_W-1:0]  soft_int_i,
  input logic [LVL_W-1:0]   pil_i,
  input logic               int_en_i,
  input logic [TL_W-1:0]    trap_lvl_i,
  input logic [TT_W-1:0]    trap_type_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o
);
  AST_NOTHING_PENDING_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_lvl_i == '0 && soft_int_i == '0) |=> (!irq_o && vec_o == '0)); // R3

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0); // R3

  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[7:4] == 4'h4 && vec_o[3:0] != 4'h0)); // R5

  AST_RAISE_ABOVE_PIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> vec_o[3:0] > $past(pil_i)); // R4

  AST_DISABLED_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |=> !irq_o); // R7

  AST_TRAP_BLOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_lvl_i != '0 && trap_type_i > TT_W'(9'h04F) && int_en_i
     && ext_lvl_i[15] && pil_i != 4'hF) |=> vec_o == $past(vec_o)); // R6
endmodule

bind irq_level_arb irq_level_arb_chk #(.TL_W(TL_W), .TT_W(TT_W)) i_chk (.*);

// File: tb/test_irq_level_arb.sv
module test_irq_level_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ext_lvl_i = '0;
  logic [16:0] soft_int_i = '0;
  logic [3:0]  pil_i = '0;
  logic        int_en_i = 1'b1;
  logic [2:0]  trap_lvl_i = '0;
  logic [8:0]  trap_type_i = '0;
  logic        irq_o;
  logic [7:0]  vec_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_level_arb i_irq_level_arb (.*);

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_out(string req, logic e_irq, logic [7:0] e_vec);
    n_run++;
    if (irq_o !== e_irq || vec_o !== e_vec) begin
      n_fail++;
      $display("FAIL %s: irq=%b vec=%h expected irq=%b vec=%h", req, irq_o, vec_o, e_irq, e_vec);
    end
  endtask

  task automatic set_in(logic [15:0] e, logic [16:0] s, logic [3:0] p, logic en,
                        logic [2:0] tl, logic [8:0] tt);
    ext_lvl_i = e; soft_int_i = s; pil_i = p; int_en_i = en;
    trap_lvl_i = tl; trap_type_i = tt;
    step();
  endtask

  task automatic clear_all();
    set_in('0, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R3 clear", 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    expect_out("R9 reset state", 1'b0, 8'h00);
  endtask

  task automatic t_merge();
    clear_all();
    set_in(16'h0020, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R1 ext level 5", 1'b1, 8'h45);
    clear_all();
    set_in('0, 17'h00080, 4'd0, 1'b1, '0, '0);
    expect_out("R1 soft level 7", 1'b1, 8'h47);
    clear_all();
    set_in(16'h0008, 17'h00400, 4'd0, 1'b1, '0, '0);
    expect_out("R1 or of ext 3 and soft 10", 1'b1, 8'h4A);
  endtask

  task automatic t_timer();
    clear_all();
    set_in('0, 17'h00001, 4'd0, 1'b1, '0, '0);
    expect_out("R2 tick bit to level 14", 1'b1, 8'h4E);
    clear_all();
    set_in('0, 17'h10000, 4'd0, 1'b1, '0, '0);
    expect_out("R2 stick bit to level 14", 1'b1, 8'h4E);
    clear_all();
    // tick bit alone must not also pend level 0: level 14 still wins, and pil 14 masks it
    set_in('0, 17'h00001, 4'd14, 1'b1, '0, '0);
    expect_out("R2 timer level masked at pil 14", 1'b0, 8'h00);
  endtask

  task automatic t_threshold();
    clear_all();
    set_in(16'h0020, '0, 4'd4, 1'b1, '0, '0);
    expect_out("R4 level 5 above pil 4", 1'b1, 8'h45);
    set_in(16'h0020, '0, 4'd5, 1'b1, '0, '0);
    expect_out("R3 level 5 at pil 5 clears", 1'b0, 8'h00);
    set_in(16'h8000, '0, 4'd15, 1'b1, '0, '0);
    expect_out("R3 pil 15 blocks all", 1'b0, 8'h00);
    set_in(16'h8000, '0, 4'd14, 1'b1, '0, '0);
    expect_out("R5 level 15 vector", 1'b1, 8'h4F);
  endtask

  task automatic t_priority();
    clear_all();
    set_in(16'h1208, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R4 highest of 3,9,12", 1'b1, 8'h4C);
    set_in(16'h1208, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R8 unchanged vector holds", 1'b1, 8'h4C);
    set_in(16'h0208, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R8 lower winner updates", 1'b1, 8'h49);
  endtask

  task automatic t_disable();
    clear_all();
    set_in(16'h0040, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R7 setup level 6", 1'b1, 8'h46);
    set_in(16'h0040, '0, 4'd0, 1'b0, '0, '0);
    expect_out("R7 disable clears", 1'b0, 8'h00);
    set_in(16'h0040, '0, 4'd0, 1'b0, '0, '0);
    expect_out("R7 stays clear while disabled", 1'b0, 8'h00);
    set_in(16'h0040, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R7 re-enable raises", 1'b1, 8'h46);
  endtask

  task automatic t_trap_block();
    clear_all();
    set_in(16'h0020, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R6 setup level 5", 1'b1, 8'h45);
    set_in(16'h0200, '0, 4'd0, 1'b1, 3'd1, 9'h04A);
    expect_out("R6 blocked by higher trap type", 1'b1, 8'h45);
    set_in(16'h0200, '0, 4'd0, 1'b1, 3'd1, 9'h049);
    expect_out("R6 equal trap type not blocking", 1'b1, 8'h49);
    set_in(16'h0800, '0, 4'd0, 1'b1, 3'd0, 9'h1FF);
    expect_out("R6 trap level zero ignores type", 1'b1, 8'h4B);
    clear_all();
    set_in(16'h0004, '0, 4'd0, 1'b1, 3'd2, 9'h060);
    expect_out("R6 blocked from idle stays idle", 1'b0, 8'h00);
  endtask

  task automatic t_reset_mid();
    set_in(16'h0100, '0, 4'd0, 1'b1, '0, '0);
    expect_out("R8 setup level 8", 1'b1, 8'h48);
    #1 rst_ni = 1'b0;
    #1 expect_out("R9 async reset clears", 1'b0, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_merge();
    t_timer();
    t_threshold();
    t_priority();
    t_disable();
    t_trap_block();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule